// File: doc/BRIEF.md
# Bit-Alias Bus Bridge

This bridge sits between a bus master and a memory port. It gives software a way to touch one bit of memory with a single ordinary load or store. Each 32-bit word in an alias window stands for exactly one bit of a backing region. A load from an alias word returns that bit as 0 or 1. A store to an alias word changes only that bit. The bridge does this as a locked read-modify-write on the downstream port, so no other master can get between the read and the write-back.

Two alias windows are decoded, each 32 MB long. The window at 0x22000000 maps onto the region at 0x20000000, and the window at 0x42000000 maps onto the region at 0x40000000. The access size (byte, halfword or word) selects the width of the backing unit and how many bits of the alias offset form the bit index. Both ports use a request/ready handshake, and only one transaction is handled at a time. Accesses that hit neither window are refused with an error and cause no downstream activity.

Top module: `bitalias_bridge`

## Requirements
- R1: An upstream address in [0x22000000, 0x23FFFFFF] targets byte address 0x20000000 | (addr[24:0] >> 5). An address in [0x42000000, 0x43FFFFFF] targets 0x40000000 | (addr[24:0] >> 5).
- R2: The size codes are 0 = byte, 1 = halfword and 2 = word. The bit index is addr[6:2] masked to its low 3, 4 or 5 bits for byte, halfword or word. The target address has bit 0 cleared for a halfword and bits 1:0 cleared for a word. The downstream size equals the upstream size.
- R3: A read issues exactly one downstream read, with the lock output low. It returns up_rdata = 1 if the selected bit of the unit is set and 0 otherwise. All other result bits are zero.
- R4: A write issues a downstream read and then a downstream write to the same address and size. The write data is the unit that was read, with the selected bit set when up_wdata[0] is 1 and cleared when it is 0. All other bits are unchanged. A write answers with up_rdata = 0.
- R5: The lock output is high from the start of the read phase of a write until the write-back completes, without a gap. It is low at every other time.
- R6: up_ready is a single-cycle pulse. It comes only after every downstream phase of the transaction has completed, and it never appears while a downstream request is pending.
- R7: A downstream error is reported as up_err together with up_ready, with up_rdata = 0. If the read phase of a write returns an error, no write-back is issued.
- R8: An address outside both windows, or size code 3, is answered with up_err and no downstream request.
- R9: Downstream data is right-justified: a unit occupies bits [8*bytes-1:0] and the upper bits are zero. Bit index 0 is the least significant bit of the lowest-addressed byte.
- R10: While reset is applied, and after it is released, up_ready, up_err, dn_req and dn_lock are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | 1 | Upstream request, held until up_ready |
| up_addr | input | ADDR_W | Upstream alias address |
| up_size | input | 2 | Access size code |
| up_wr | input | 1 | 1 = write, 0 = read |
| up_wdata | input | DATA_W | Write data; only bit 0 is used |
| up_ready | output | 1 | Completion pulse |
| up_rdata | output | DATA_W | Read result (0 or 1) |
| up_err | output | 1 | Error response, valid with up_ready |
| dn_req | output | 1 | Downstream request |
| dn_addr | output | ADDR_W | Downstream byte address |
| dn_size | output | 2 | Downstream size code |
| dn_wr | output | 1 | Downstream write flag |
| dn_wdata | output | DATA_W | Downstream write data, right-justified |
| dn_lock | output | 1 | Locked-sequence indication |
| dn_ready | input | 1 | Downstream completion |
| dn_rdata | input | DATA_W | Downstream read data, right-justified |
| dn_err | input | 1 | Downstream error, valid with dn_ready |

## Verification
The bench uses the default parameters: 32-bit address and data, a 25-bit window span, and the two window bases. With these values both alias windows, their first and last alias words, and the addresses just outside each window can all be reached with ordinary 32-bit addresses. The word size also reaches bit index 31, the largest bit index. The bench varies the downstream latency from zero to two wait cycles. It injects errors on the read phase and on the write-back phase.

// File: rtl/bba_pkg.sv
package bba_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } bba_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WB   = 2'd2,
    ST_DONE = 2'd3
  } bba_state_e;

  // 8 bits per byte times 4 alias bytes per bit
  localparam int ALIAS_SHIFT = 5;
endpackage

// File: rtl/bba_decode.sv
module bba_decode
  import bba_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int SPAN_W  = 25,
  parameter int NUM_WIN = 2,
  parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] REGION_BASE = {32'h4000_0000, 32'h2000_0000},
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              hit,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [IDX_W-1:0]  bit_idx
);
  logic [NUM_WIN-1:0] win_hit;
  logic [ADDR_W-1:0]  win_tgt [NUM_WIN];
  logic               any_hit;
  logic [ADDR_W-1:0]  tgt_raw;
  logic [IDX_W-1:0]   idx_raw;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign win_hit[w] = (addr[ADDR_W-1:SPAN_W] ==
                         ALIAS_BASE[w*ADDR_W+SPAN_W +: ADDR_W-SPAN_W]);
    assign win_tgt[w] = REGION_BASE[w*ADDR_W +: ADDR_W] |
                        ADDR_W'(addr[SPAN_W-1:0] >> ALIAS_SHIFT);
  end

  always_comb begin
    any_hit = 1'b0;
    tgt_raw = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (win_hit[w]) begin
        any_hit = 1'b1;
        tgt_raw = win_tgt[w];
      end
    end
  end

  assign idx_raw  = addr[IDX_W+1:2];
  assign hit      = any_hit && (size != SZ_BAD);
  assign tgt_addr = tgt_raw & ~ADDR_W'((32'd1 << size) - 32'd1);
  assign bit_idx  = idx_raw & IDX_W'((32'd8 << size) - 32'd1);
endmodule

// File: rtl/bba_merge.sv
module bba_merge #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] unit_in,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              set_val,
  output logic              bit_val,
  output logic [DATA_W-1:0] unit_out
);
  logic [DATA_W-1:0] sel_mask;

  assign sel_mask = DATA_W'(1) << bit_idx;
  assign bit_val  = unit_in[bit_idx];
  assign unit_out = set_val ? (unit_in | sel_mask) : (unit_in & ~sel_mask);
endmodule

// File: rtl/bba_seq.sv
module bba_seq
  import bba_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req,
  input  logic              up_wr,
  input  logic              up_set,
  input  logic [1:0]        up_size,
  input  logic              dec_hit,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic [IDX_W-1:0]  dec_idx,
  input  logic              dn_ready,
  input  logic              dn_err,
  input  logic              mrg_bit,
  input  logic [DATA_W-1:0] mrg_unit,
  output logic [IDX_W-1:0]  idx_q,
  output logic              set_q,
  output logic              up_ready,
  output logic              rsp_bit,
  output logic              up_err,
  output logic              dn_req,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [1:0]        dn_size,
  output logic              dn_wr,
  output logic [DATA_W-1:0] dn_wdata,
  output logic              dn_lock
);
  bba_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic              wr_q;
  logic [DATA_W-1:0] wb_q;
  logic              rbit_q, err_q;
  logic              cap_en, wb_en, rsp_en;
  logic              rbit_d, err_d;

  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    wb_en   = 1'b0;
    rsp_en  = 1'b0;
    rbit_d  = 1'b0;
    err_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (up_req) begin
          if (dec_hit) begin
            cap_en  = 1'b1;
            state_d = ST_RD;
          end else begin
            rsp_en  = 1'b1;
            err_d   = 1'b1;
            state_d = ST_DONE;
          end
        end
      end
      ST_RD: begin
        if (dn_ready) begin
          if (dn_err) begin
            rsp_en  = 1'b1;
            err_d   = 1'b1;
            state_d = ST_DONE;
          end else if (wr_q) begin
            wb_en   = 1'b1;
            state_d = ST_WB;
          end else begin
            rsp_en  = 1'b1;
            rbit_d  = mrg_bit;
            state_d = ST_DONE;
          end
        end
      end
      ST_WB: begin
        if (dn_ready) begin
          rsp_en  = 1'b1;
          err_d   = dn_err;
          state_d = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      size_q  <= '0;
      idx_q   <= '0;
      set_q   <= 1'b0;
      wr_q    <= 1'b0;
      wb_q    <= '0;
      rbit_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        addr_q <= dec_addr;
        size_q <= up_size;
        idx_q  <= dec_idx;
        set_q  <= up_set;
        wr_q   <= up_wr;
      end
      if (wb_en) begin
        wb_q <= mrg_unit;
      end
      if (rsp_en) begin
        rbit_q <= rbit_d;
        err_q  <= err_d;
      end
    end
  end

  assign dn_req   = (state_q == ST_RD) || (state_q == ST_WB);
  assign dn_wr    = (state_q == ST_WB);
  assign dn_lock  = dn_req && wr_q;
  assign dn_addr  = addr_q;
  assign dn_size  = size_q;
  assign dn_wdata = dn_wr ? wb_q : '0;
  assign up_ready = (state_q == ST_DONE);
  assign rsp_bit  = up_ready && rbit_q;
  assign up_err   = up_ready && err_q;
endmodule

// File: rtl/bitalias_bridge.sv
module bitalias_bridge
  import bba_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int SPAN_W  = 25,
  parameter int NUM_WIN = 2,
  parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] REGION_BASE = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [1:0]        up_size,
  input  logic              up_wr,
  input  logic [DATA_W-1:0] up_wdata,
  output logic              up_ready,
  output logic [DATA_W-1:0] up_rdata,
  output logic              up_err,
  output logic              dn_req,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [1:0]        dn_size,
  output logic              dn_wr,
  output logic [DATA_W-1:0] dn_wdata,
  output logic              dn_lock,
  input  logic              dn_ready,
  input  logic [DATA_W-1:0] dn_rdata,
  input  logic              dn_err
);
  localparam int IDX_W = $clog2(DATA_W);

  logic              rst_meta, rst_sync;
  logic              dec_hit;
  logic [ADDR_W-1:0] dec_addr;
  logic [IDX_W-1:0]  dec_idx;
  logic [IDX_W-1:0]  idx_q;
  logic              set_q;
  logic              mrg_bit;
  logic [DATA_W-1:0] mrg_unit;
  logic              rsp_bit;
  logic              unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign unused_wdata = ^up_wdata[DATA_W-1:1];

  bba_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPAN_W(SPAN_W), .NUM_WIN(NUM_WIN),
    .ALIAS_BASE(ALIAS_BASE), .REGION_BASE(REGION_BASE)
  ) u_decode (
    .addr(up_addr), .size(up_size),
    .hit(dec_hit), .tgt_addr(dec_addr), .bit_idx(dec_idx)
  );

  bba_merge #(.DATA_W(DATA_W)) u_merge (
    .unit_in(dn_rdata), .bit_idx(idx_q), .set_val(set_q),
    .bit_val(mrg_bit), .unit_out(mrg_unit)
  );

  bba_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_sync),
    .up_req(up_req), .up_wr(up_wr), .up_set(up_wdata[0]), .up_size(up_size),
    .dec_hit(dec_hit), .dec_addr(dec_addr), .dec_idx(dec_idx),
    .dn_ready(dn_ready), .dn_err(dn_err),
    .mrg_bit(mrg_bit), .mrg_unit(mrg_unit),
    .idx_q(idx_q), .set_q(set_q),
    .up_ready(up_ready), .rsp_bit(rsp_bit), .up_err(up_err),
    .dn_req(dn_req), .dn_addr(dn_addr), .dn_size(dn_size), .dn_wr(dn_wr),
    .dn_wdata(dn_wdata), .dn_lock(dn_lock)
  );

  assign up_rdata = {{(DATA_W-1){1'b0}}, rsp_bit};
endmodule

// File: rtl/bba_checker.sv
module bba_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_ready,
  input logic [DATA_W-1:0] up_rdata,
  input logic              up_err,
  input logic              dn_req,
  input logic [ADDR_W-1:0] dn_addr,
  input logic [1:0]        dn_size,
  input logic              dn_wr,
  input logic              dn_lock,
  input logic              dn_ready,
  input logic              dn_err
);
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |=> !up_ready); // R6
  AST_NO_READY_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> !up_ready); // R6
  AST_READ_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ready && !up_err) |-> (up_rdata[DATA_W-1:1] == '0)); // R3
  AST_LOCK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dn_lock |-> dn_req); // R5
  AST_WB_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && dn_wr) |-> dn_lock); // R5
  AST_LOCK_CARRIES: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && dn_ready && !dn_wr && dn_lock && !dn_err)
      |=> (dn_req && dn_wr && dn_lock && $stable(dn_addr) && $stable(dn_size))); // R4
  AST_NO_WB_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && dn_ready && !dn_wr && dn_err) |=> !dn_req); // R7
  AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && !dn_ready)
      |=> (dn_req && $stable(dn_addr) && $stable(dn_wr) && $stable(dn_size))); // R6
endmodule

bind bitalias_bridge bba_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_ready(up_ready), .up_rdata(up_rdata),
  .up_err(up_err), .dn_req(dn_req), .dn_addr(dn_addr), .dn_size(dn_size),
  .dn_wr(dn_wr), .dn_lock(dn_lock), .dn_ready(dn_ready), .dn_err(dn_err)
);

// File: tb/bitalias_bridge_tb.sv
module bitalias_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_req = 1'b0;
  logic [31:0] up_addr = '0;
  logic [1:0]  up_size = '0;
  logic        up_wr = 1'b0;
  logic [31:0] up_wdata = '0;
  logic        up_ready;
  logic [31:0] up_rdata;
  logic        up_err;
  logic        dn_req;
  logic [31:0] dn_addr;
  logic [1:0]  dn_size;
  logic        dn_wr;
  logic [31:0] dn_wdata;
  logic        dn_lock;
  logic        dn_ready = 1'b0;
  logic [31:0] dn_rdata = '0;
  logic        dn_err = 1'b0;

  typedef struct {
    logic [31:0] a;
    logic [1:0]  sz;
    bit          wr;
    logic [31:0] wd;
    bit          lock;
    bit          err;
  } dn_op_t;

  dn_op_t      exp_q[$];
  logic [7:0]  mem [logic [31:0]];
  int          n_chk = 0;
  int          n_err = 0;
  int          lat = 0;
  int          waitc = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  bitalias_bridge u_dut (
    .clk(clk), .rst_n(rst_n),
    .up_req(up_req), .up_addr(up_addr), .up_size(up_size), .up_wr(up_wr),
    .up_wdata(up_wdata), .up_ready(up_ready), .up_rdata(up_rdata), .up_err(up_err),
    .dn_req(dn_req), .dn_addr(dn_addr), .dn_size(dn_size), .dn_wr(dn_wr),
    .dn_wdata(dn_wdata), .dn_lock(dn_lock), .dn_ready(dn_ready),
    .dn_rdata(dn_rdata), .dn_err(dn_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_byte(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [31:0] get_unit(input logic [31:0] a, input int sz);
    logic [31:0] v = '0;
    for (int i = 0; i < (1 << sz); i++) v = v | (32'(rd_byte(a + i)) << (8 * i));
    return v;
  endfunction

  task automatic put_unit(input logic [31:0] a, input int sz, input logic [31:0] v);
    for (int i = 0; i < (1 << sz); i++) mem[a + i] = v[8*i +: 8];
  endtask

  // downstream memory model, one request served at a time
  always @(negedge clk) begin
    if (!rst_n) begin
      dn_ready = 0; dn_err = 0; dn_rdata = '0; waitc = 0;
    end else if (dn_ready) begin
      dn_ready = 0; dn_err = 0; dn_rdata = '0; waitc = 0;
    end else if (dn_req) begin
      if (exp_q.size() != 0)
        check(dn_lock == exp_q[0].lock, "R5", "lock during request", 32'(dn_lock), 32'(exp_q[0].lock));
      if (waitc < lat) begin
        waitc++;
      end else if (exp_q.size() == 0) begin
        check(0, "R8", "unexpected downstream request", dn_addr, 32'h0);
        dn_ready = 1; dn_err = 1;
      end else begin
        dn_op_t op;
        op = exp_q.pop_front();
        check(dn_addr == op.a, "R1", "downstream address", dn_addr, op.a);
        check(dn_size == op.sz, "R2", "downstream size", 32'(dn_size), 32'(op.sz));
        check(dn_wr == op.wr, "R4", "downstream direction", 32'(dn_wr), 32'(op.wr));
        if (op.wr) begin
          check(dn_wdata == op.wd, "R4", "write-back data", dn_wdata, op.wd);
          if (!op.err) put_unit(dn_addr, int'(dn_size), dn_wdata);
        end else begin
          dn_rdata = get_unit(dn_addr, int'(dn_size));
        end
        dn_err = op.err;
        dn_ready = 1;
      end
    end else begin
      check(dn_lock == 1'b0, "R5", "lock while idle", 32'(dn_lock), 32'h0);
    end
  end

  task automatic txn(input logic [31:0] a, input int sz, input bit wr, input bit val,
                     input bit rd_err, input bit wb_err, input string req);
    logic [31:0] base, tgt, unit, nu, exp_rd;
    bit          miss, exp_err;
    int          b;
    dn_op_t      op;
    int          cyc;
    miss = 0; base = '0;
    if (a >= 32'h2200_0000 && a < 32'h2400_0000) base = 32'h2000_0000;
    else if (a >= 32'h4200_0000 && a < 32'h4400_0000) base = 32'h4000_0000;
    else miss = 1;
    if (sz == 3) miss = 1;
    exp_rd = '0; exp_err = 0;
    if (miss) begin
      exp_err = 1;
    end else begin
      tgt = (base | ((a & 32'h01FF_FFFF) >> 5)) & ~((32'd1 << sz) - 1);
      b = int'((a >> 2) % (8 << sz));
      unit = get_unit(tgt, sz);
      op.a = tgt; op.sz = 2'(sz); op.wr = 0; op.wd = '0; op.lock = wr; op.err = rd_err;
      exp_q.push_back(op);
      if (rd_err) exp_err = 1;
      else if (!wr) exp_rd = 32'((unit >> b) & 1);
      else begin
        nu = val ? (unit | (32'd1 << b)) : (unit & ~(32'd1 << b));
        op.wr = 1; op.wd = nu; op.lock = 1; op.err = wb_err;
        exp_q.push_back(op);
        exp_err = wb_err;
      end
    end
    up_req = 1; up_addr = a; up_size = 2'(sz); up_wr = wr;
    up_wdata = {31'h2AAA_AAAA, val};
    cyc = 0;
    while (!up_ready && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    check(up_ready == 1'b1, req, "completion seen", 32'(up_ready), 32'h1);
    check(exp_q.size() == 0, "R6", "ready before downstream done", 32'(exp_q.size()), 32'h0);
    check(up_err == exp_err, req, "error response", 32'(up_err), 32'(exp_err));
    check(up_rdata == exp_rd, req, "read result", up_rdata, exp_rd);
    up_req = 0;
    exp_q.delete();
    @(negedge clk);
    check(up_ready == 1'b0, "R6", "ready is one pulse", 32'(up_ready), 32'h0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R6", "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(up_ready == 0 && up_err == 0, "R10", "upstream idle in reset", {30'h0, up_ready, up_err}, 32'h0);
    check(dn_req == 0 && dn_lock == 0, "R10", "downstream idle in reset", {30'h0, dn_req, dn_lock}, 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(up_ready == 0 && dn_req == 0 && dn_lock == 0, "R10", "idle after release",
          {29'h0, up_ready, dn_req, dn_lock}, 32'h0);

    for (int l = 0; l < 3; l++) begin
      lat = l;
      // reads in both windows, all sizes (R1 R2 R3)
      txn(32'h2200_0000, 0, 0, 0, 0, 0, "R3");
      txn(32'h2200_0ABC, 0, 0, 0, 0, 0, "R3");
      txn(32'h2200_1234, 1, 0, 0, 0, 0, "R2");
      txn(32'h2200_567C, 2, 0, 0, 0, 0, "R2");
      txn(32'h4200_0F9C, 2, 0, 0, 0, 0, "R1");
      txn(32'h23FF_FFFC, 2, 0, 0, 0, 0, "R1");
      txn(32'h43FF_FFFF, 0, 0, 0, 0, 0, "R1");
      // writes set and clear, then read back (R4 R9)
      txn(32'h2200_001C, 0, 1, 1, 0, 0, "R4");
      txn(32'h2200_001C, 0, 0, 0, 0, 0, "R9");
      txn(32'h2200_001C, 0, 1, 0, 0, 0, "R4");
      txn(32'h2200_001C, 0, 0, 0, 0, 0, "R9");
      txn(32'h4200_20BC, 1, 1, 1, 0, 0, "R4");
      txn(32'h4200_20BC, 1, 0, 0, 0, 0, "R9");
      txn(32'h2200_307C, 2, 1, 1, 0, 0, "R4");
      txn(32'h2200_307C, 2, 0, 0, 0, 0, "R9");
      txn(32'h4200_3000, 2, 1, 0, 0, 0, "R4");
      txn(32'h4200_3000, 2, 0, 0, 0, 0, "R9");
      // refused accesses (R8)
      txn(32'h21FF_FFFC, 2, 0, 0, 0, 0, "R8");
      txn(32'h2400_0000, 0, 1, 1, 0, 0, "R8");
      txn(32'h41FF_FFFC, 0, 0, 0, 0, 0, "R8");
      txn(32'h4400_0000, 2, 1, 1, 0, 0, "R8");
      txn(32'h0000_0000, 0, 0, 0, 0, 0, "R8");
      txn(32'h2200_0040, 3, 1, 1, 0, 0, "R8");
      // downstream errors (R7)
      txn(32'h2200_0100, 0, 0, 0, 1, 0, "R7");
      txn(32'h2200_0104, 0, 1, 1, 1, 0, "R7");
      txn(32'h2200_0104, 0, 0, 0, 0, 0, "R7");
      txn(32'h4200_0208, 1, 1, 1, 0, 1, "R7");
      txn(32'h4200_0208, 1, 0, 0, 0, 0, "R7");
    end
    finish_run();
  end
endmodule